// File: doc/BRIEF.md
# Host-to-Memory Transaction Width Splitter

This block sits between a host bus and an asynchronous NAND-style external memory whose data port is either 8 or 16 bits wide. A host request carries a byte address, a size code (8, 16 or 32 bits), a read/write flag and write data. The block turns it into a fixed number of narrow memory accesses, issued one at a time in ascending address order. For reads, it collects the returned data into the full host word. When the last narrow access completes, it returns one response.

A single configuration input selects the memory port width. The block samples it when it accepts a request. A byte write to a 16-bit port cannot be performed, and the reserved size code is meaningless. Either one is refused with an error response, and no memory access is started. The block accepts only one host request at a time. It takes no new request until the current one has fully completed.

Top module: `width_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid` and `rsp_valid` are 0.
- R2: Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = reserved. With `cfg_wide` = 0 (8-bit port), sizes 0, 1 and 2 take exactly 1, 2 and 4 memory accesses, for both reads and writes.
- R3: With `cfg_wide` = 1 (16-bit port):
  - a 16-bit access takes one memory access;
  - a 32-bit access takes two memory accesses;
  - an 8-bit read takes one memory access.
- R4: An 8-bit write with `cfg_wide` = 1, or any request with size code 3, is refused. In the cycle after acceptance, `rsp_valid` and `rsp_error` are 1, and no memory access is issued. All other requests respond with `rsp_error` = 0.
- R5: Memory accesses use ascending addresses.
  - On an 8-bit port, access i uses `req_addr`+i.
  - On a 16-bit port, access i uses (`req_addr` with bit 0 cleared)+2i.
  - Address arithmetic wraps at the address width.
- R6: Write data is sent least significant part first.
  - On an 8-bit port, access i carries byte i of `req_wdata` in `mem_wdata[7:0]`.
  - On a 16-bit port, access i carries halfword i of `req_wdata`.
- R7: Read data is assembled little-endian.
  - On an 8-bit port, `mem_rdata[7:0]` of access i lands in byte lane i, and `mem_rdata[15:8]` is ignored.
  - On a 16-bit port, access i fills halfword i.
  - An 8-bit read on a 16-bit port takes the byte selected by `req_addr[0]` (1 = upper) into lane 0.
  - Lanes beyond the request size read as 0.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` hold their values.
- R9: `req_ready` stays 0 from the cycle after acceptance until the cycle after the response. `rsp_valid` is a one-cycle pulse in the cycle after the final memory handshake.
- R10: Request fields are captured at acceptance. Changes to host inputs during a transaction have no effect, and `mem_write` equals the captured write flag on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | Memory port width: 0 = 8 bits, 1 = 16 bits |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Host byte address |
| req_size | input | 2 | 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_error | output | 1 | Request was refused |
| rsp_rdata | output | 32 | Assembled read data |
| mem_valid | output | 1 | Narrow access request |
| mem_ready | input | 1 | Narrow access completes this cycle |
| mem_addr | output | AW | Narrow access byte address |
| mem_write | output | 1 | Narrow access direction |
| mem_wdata | output | 16 | Narrow write data |
| mem_rdata | input | 16 | Narrow read data |

## Verification
A wrong beat counter or captured plan shows up as a response arriving one or more handshakes too early or too late, or as a missing or extra `mem_valid` cycle. The bench sees this at the very transaction where it happens. A wrong address step or data shift corrupts the address or write data of the second beat. A lane-select fault leaves a byte of `rsp_rdata` wrong in that transaction's single response. Every transaction is swept over both port widths, all four size codes, both directions, aligned and odd addresses near the wrap point, and memory latencies of 0 to 2 cycles, so each fault is exposed within a few cycles of its cause.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } host_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_RESP = 2'd2
  } split_state_e;
endpackage

// File: rtl/ws_plan.sv
module ws_plan
  import ws_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          wide,
  input  logic [1:0]    size,
  input  logic          write,
  output logic          refuse,
  output logic [CW-1:0] nbeats
);
  always_comb begin
    refuse = 1'b0;
    nbeats = CW'(1);
    unique case (host_size_e'(size))
      SZ_BYTE: begin
        nbeats = CW'(1);
        refuse = wide & write;
      end
      SZ_HALF: nbeats = wide ? CW'(1) : CW'(2);
      SZ_WORD: nbeats = wide ? CW'(2) : CW'(4);
      default: refuse = 1'b1;
    endcase
  end
endmodule

// File: rtl/ws_gather.sv
module ws_gather #(
  parameter int NLANE = 4,
  parameter int BW    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               capture,
  input  logic               wide,
  input  logic               narrow_byte,
  input  logic               byte_sel,
  input  logic [BW-1:0]      beat,
  input  logic [15:0]        rdata,
  output logic [8*NLANE-1:0] word
);
  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    always_comb begin
      if (!wide) begin
        hit = (int'(beat) == j);
        src = rdata[7:0];
      end else if (narrow_byte) begin
        hit = (j == 0) && (beat == '0);
        src = byte_sel ? rdata[15:8] : rdata[7:0];
      end else begin
        hit = (int'(beat) == j / 2);
        src = rdata[8*(j%2) +: 8];
      end
    end
    always_ff @(posedge clk) begin
      if (rst || clear) word[8*j +: 8] <= 8'h00;
      else if (capture && hit) word[8*j +: 8] <= src;
    end
  end
endmodule

// File: rtl/width_splitter.sv
module width_splitter
  import ws_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wide,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_error,
  output logic [31:0]   rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_write,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int HW    = 32;
  localparam int NLANE = HW / 8;
  localparam int CW    = $clog2(NLANE) + 1;
  localparam int BW    = $clog2(NLANE);

  split_state_e st;
  logic          refuse;
  logic [CW-1:0] plan_n;
  logic [CW-1:0] nb_q;
  logic [BW-1:0] idx;
  logic          wide_q, nbyte_q, bsel_q, err_q;
  logic [HW-1:0] wd_q;
  logic          accept, hs, last;

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_error = err_q;
  assign accept    = req_valid && req_ready;
  assign hs        = mem_valid && mem_ready;
  assign last      = ({1'b0, idx} == nb_q - CW'(1));

  ws_plan #(.CW(CW)) u_plan (
    .wide  (cfg_wide),
    .size  (req_size),
    .write (req_write),
    .refuse(refuse),
    .nbeats(plan_n)
  );

  ws_gather #(.NLANE(NLANE), .BW(BW)) u_gather (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .capture    (hs),
    .wide       (wide_q),
    .narrow_byte(nbyte_q),
    .byte_sel   (bsel_q),
    .beat       (idx),
    .rdata      (mem_rdata),
    .word       (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_write <= 1'b0;
      mem_wdata <= '0;
      err_q     <= 1'b0;
      nb_q      <= '0;
      idx       <= '0;
      wide_q    <= 1'b0;
      nbyte_q   <= 1'b0;
      bsel_q    <= 1'b0;
      wd_q      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          err_q   <= refuse;
          nb_q    <= plan_n;
          idx     <= '0;
          wide_q  <= cfg_wide;
          nbyte_q <= (req_size == SZ_BYTE);
          bsel_q  <= req_addr[0];
          if (refuse) begin
            st <= ST_RESP;
          end else begin
            st        <= ST_BUSY;
            mem_valid <= 1'b1;
            mem_write <= req_write;
            if (cfg_wide) begin
              mem_addr  <= {req_addr[AW-1:1], 1'b0};
              mem_wdata <= req_wdata[15:0];
              wd_q      <= req_wdata >> 16;
            end else begin
              mem_addr  <= req_addr;
              mem_wdata <= {8'h00, req_wdata[7:0]};
              wd_q      <= req_wdata >> 8;
            end
          end
        end
        ST_BUSY: if (hs) begin
          if (last) begin
            mem_valid <= 1'b0;
            st        <= ST_RESP;
          end else begin
            idx <= idx + BW'(1);
            if (wide_q) begin
              mem_addr  <= mem_addr + AW'(2);
              mem_wdata <= wd_q[15:0];
              wd_q      <= wd_q >> 16;
            end else begin
              mem_addr  <= mem_addr + AW'(1);
              mem_wdata <= {8'h00, wd_q[7:0]};
              wd_q      <= wd_q >> 8;
            end
          end
        end
        default: begin
          st    <= ST_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end

  a_r4_refuse_responds: assert property (@(posedge clk) disable iff (rst)
    (accept && refuse) |=> (rsp_valid && rsp_error && !mem_valid));
  a_r8_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));
  a_r9_one_cycle_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !req_ready);
  a_r4_error_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_error |-> rsp_valid);
  a_r2_beat_in_range: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ({1'b0, idx} < nb_q));
  a_r9_rsp_after_last: assert property (@(posedge clk) disable iff (rst)
    (hs && last) |=> (rsp_valid && !mem_valid));
endmodule

// File: tb/test_width_splitter.sv
module test_width_splitter;
  localparam int AW = 16;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wide = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_error;
  logic [31:0]   rsp_rdata;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_write;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #(TCLK/2) clk = ~clk;

  width_splitter #(.AW(AW)) i_width_splitter (.*);

  function automatic logic [7:0] bval(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a * AW'(37) + AW'(11);
    return t[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic run(input bit wide, input logic [1:0] size, input bit wr,
                     input logic [AW-1:0] addr, input logic [31:0] wd, input int lat);
    bit            refuse;
    int            nexp, beats, waitc, cycles;
    logic [AW-1:0] base, ea, hold_a;
    logic [31:0]   erd;
    logic [15:0]   ewd, hold_d;
    logic          hold_w;
    refuse = (size == 2'd3) || (wide && size == 2'd0 && wr);
    if (refuse) nexp = 0;
    else if (wide) nexp = (size == 2'd2) ? 2 : 1;
    else nexp = 1 << size;
    base = wide ? {addr[AW-1:1], 1'b0} : addr;
    erd = '0;
    if (!refuse) begin
      if (wide && size == 2'd0) erd[7:0] = bval(addr);
      else for (int i = 0; i < (1 << size); i++) erd[8*i +: 8] = bval(base + AW'(i));
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "ready idle", {31'b0, req_ready}, 1);
    cfg_wide = wide; req_size = size; req_write = wr; req_addr = addr;
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble host inputs after acceptance
    req_addr = ~addr; req_wdata = ~wd; req_write = ~wr; req_size = ~size;
    cfg_wide = ~wide;
    beats = 0; waitc = 0; cycles = 0;
    hold_a = '0; hold_d = '0; hold_w = 1'b0;
    while (!rsp_valid && cycles < 60) begin
      mem_ready = 1'b0;
      chk(req_ready === 1'b0, "R9", "ready busy", {31'b0, req_ready}, 0);
      if (mem_valid) begin
        if (waitc == 0) begin
          ea = wide ? base + AW'(2 * beats) : addr + AW'(beats);
          chk(mem_addr === ea, "R5", "addr", {16'b0, mem_addr}, {16'b0, ea});
          chk(mem_write === wr, "R10", "write flag", {31'b0, mem_write}, {31'b0, wr});
          if (wr) begin
            ewd = wide ? wd[16*beats +: 16] : {8'h00, wd[8*beats +: 8]};
            chk(mem_wdata === ewd, "R6", "wdata", {16'b0, mem_wdata}, {16'b0, ewd});
          end
          hold_a = mem_addr; hold_d = mem_wdata; hold_w = mem_write;
        end else begin
          chk(mem_addr === hold_a && mem_wdata === hold_d && mem_write === hold_w,
              "R8", "held", {mem_wdata, mem_addr}, {hold_d, hold_a});
        end
        if (waitc == lat) begin
          mem_ready = 1'b1;
          mem_rdata = wide ? {bval(mem_addr + AW'(1)), bval(mem_addr)}
                           : {8'hA5, bval(mem_addr)};
          beats++; waitc = 0;
        end else begin
          waitc++;
        end
      end
      @(negedge clk);
      cycles++;
    end
    mem_ready = 1'b0;
    chk(rsp_valid === 1'b1, "R9", "response seen", {31'b0, rsp_valid}, 1);
    chk(beats == nexp, refuse ? "R4" : (wide ? "R3" : "R2"), "beat count", beats, nexp);
    chk(rsp_error === refuse, "R4", "error flag", {31'b0, rsp_error}, {31'b0, refuse});
    if (refuse) chk(cycles == 0, "R4", "refuse latency", cycles, 0);
    if (!refuse && !wr) chk(rsp_rdata === erd, "R7", "rdata", rsp_rdata, erd);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9", "pulse end",
        {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [5];
    addrs = '{16'h0000, 16'h0001, 16'h0002, 16'h0103, 16'hFFFD};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1 && mem_valid === 1'b0 && rsp_valid === 1'b0, "R1",
        "reset state", {29'b0, req_ready, mem_valid, rsp_valid}, 32'd4);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 5; a++)
            for (int l = 0; l < 3; l++)
              run(w[0], s[1:0], d[0], addrs[a],
                  32'h9E37_79B9 ^ (32'(a) << 8) ^ (32'(l) << 20) ^ 32'(s), l);
    summary();
    $finish;
  end
endmodule